// File: doc/BRIEF.md
# Converter Bus Handshake Sequencer

This block is the processor-facing control logic of a two-step flash analog-to-digital converter. It runs in the system clock domain. It samples the active-low chip select, read and write strobes and a mode pin, and turns them into a single-cycle conversion-start pulse and a single-cycle result-capture pulse. It also drives the handshake outputs a host reads back. The analog front end stays outside the block: the 8-bit code and an over-range flag arrive as plain digital inputs and are captured when the capture pulse fires.

Two handshakes are supported. With the mode pin low, which is also the reset value, a read strobe starts a conversion. The data bus is driven only once the result is ready, and a ready line with open-drain semantics holds the host off until then. With the mode pin high, a write strobe starts the conversion. The result is captured a fixed number of cycles after the write strobe is released, or sooner if a read strobe arrives first.

The interrupt output falls when a fresh result has been captured. It returns high on a rising read strobe or a rising chip select. The over-range output is never placed in high impedance.

Top module: `adc_bus_seq`

## Requirements
- R1: After reset, int_n=1, rdy_oe=0, rdy_o=0, db_oe=0, ofl_n=1, and no start pulse has been issued.
- R2: While cs_n is high, rd_n and wr_n transitions issue no start_conv pulse, leave int_n high and leave db_oe low.
- R3: With mode=1 (write-then-read), a falling wr_n while cs_n is low issues exactly one start_conv pulse.
- R4: With mode=1 and no earlier read, the result is captured TIMEOUT_CYC cycles after wr_n rises, plus a synchronizer latency of at most 4 cycles. int_n stays high before that point and falls at it.
- R5: With mode=1, a falling rd_n (cs_n low) before the timeout ends captures the result within 4 cycles, and int_n falls then.
- R6: With mode=0 (read-only, the reset default), a falling rd_n with cs_n low issues one start_conv pulse. The result is captured CONV_CYC cycles later, and db_oe stays low until then even though rd_n and cs_n are low.
- R7: With mode=0, rdy_oe rises within 4 cycles of cs_n falling and falls when the result is captured. rdy_o is always 0, so the pin is either pulled low or released.
- R8: int_n returns high within 4 cycles of a rising edge of rd_n or of cs_n.
- R9: db_oe is high only while cs_n and rd_n are both low (as seen through the synchronizers). In mode=1 it is high as soon as the read is seen.
- R10: At capture, db_q takes conv_data and ofl_n takes the inverse of conv_over (low = over range). ofl_n changes at no other time.
- R11: A start strobe that arrives while a conversion is in progress is ignored: no second start_conv pulse, and the capture time is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| mode | input | 1 | 0 = read-only handshake, 1 = write-then-read |
| conv_data | input | DATA_W | Code from the converter core |
| conv_over | input | 1 | 1 when the input was above the top reference |
| start_conv | output | 1 | One-cycle pulse that begins a conversion |
| latch_res | output | 1 | One-cycle pulse that captures the result |
| db_q | output | DATA_W | Captured result for the data bus |
| db_oe | output | 1 | Data bus output enable |
| ofl_n | output | 1 | Over-range flag, active low, always driven |
| int_n | output | 1 | Result-ready interrupt, active low |
| rdy_oe | output | 1 | Ready pull-down enable (open-drain) |
| rdy_o | output | 1 | Ready data value, constant 0 |

## Verification
A wrong sequencer state would show up as a missing or extra start_conv pulse, or as int_n falling too early or too late. In write-then-read mode a timer that restarts or never expires moves the int_n edge by tens of cycles, and the bench brackets that edge from both sides. A corrupted ready or result-valid flag shows up as db_oe or rdy_oe taking the wrong level within four cycles of the strobe that should have changed it, and the bench samples each of these inside that window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WR_HELD,
    ST_WAIT,
    ST_RDCONV
  } seq_state_e;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1 <= RST_VAL[i];
          s2 <= RST_VAL[i];
        end else begin
          s1 <= d[i];
          s2 <= s1;
        end
      end
      assign q[i] = s2;
    end
  endgenerate
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= load_val;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign expired = active && (cnt == '0);

  // R4: an expiry ends the count, so the next cycle cannot expire again
  AST_SINGLE_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> !expired); // R4
endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 100,
  parameter int CONV_CYC    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              mode,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              conv_over,
  output logic              start_conv,
  output logic              latch_res,
  output logic [DATA_W-1:0] db_q,
  output logic              db_oe,
  output logic              ofl_n,
  output logic              int_n,
  output logic              rdy_oe,
  output logic              rdy_o
);
  localparam int MAX_CYC = (TIMEOUT_CYC > CONV_CYC) ? TIMEOUT_CYC : CONV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] TO_LOAD = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] CV_LOAD = CNT_W'(CONV_CYC - 1);

  logic [3:0] pins_s;
  logic cs_s, rd_s, wr_s, mode_s;
  logic cs_p, rd_p, wr_p;

  adc_seq_sync #(.W(4), .RST_VAL(4'b0111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({mode, wr_n, rd_n, cs_n}),
    .q   (pins_s)
  );

  assign cs_s   = pins_s[0];
  assign rd_s   = pins_s[1];
  assign wr_s   = pins_s[2];
  assign mode_s = pins_s[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= 1'b1;
      rd_p <= 1'b1;
      wr_p <= 1'b1;
    end else begin
      cs_p <= cs_s;
      rd_p <= rd_s;
      wr_p <= wr_s;
    end
  end

  logic sel, cs_fall, cs_rise, rd_fall, rd_rise, wr_fall, rd_act;
  assign sel     = ~cs_s;
  assign cs_fall = cs_p & ~cs_s;
  assign cs_rise = ~cs_p & cs_s;
  assign rd_fall = rd_p & ~rd_s;
  assign rd_rise = ~rd_p & rd_s;
  assign wr_fall = wr_p & ~wr_s;
  assign rd_act  = ~cs_s & ~rd_s;

  seq_state_e       state, state_nx;
  logic             start, latch, tload, expired;
  logic [CNT_W-1:0] tval;

  adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tload),
    .load_val (tval),
    .expired  (expired)
  );

  always_comb begin
    state_nx = state;
    start    = 1'b0;
    latch    = 1'b0;
    tload    = 1'b0;
    tval     = TO_LOAD;
    unique case (state)
      ST_IDLE: begin
        if (sel && mode_s && wr_fall) begin
          start    = 1'b1;
          state_nx = ST_WR_HELD;
        end else if (sel && !mode_s && rd_fall) begin
          start    = 1'b1;
          tload    = 1'b1;
          tval     = CV_LOAD;
          state_nx = ST_RDCONV;
        end
      end
      ST_WR_HELD: begin
        if (sel && rd_fall) begin
          latch    = 1'b1;
          state_nx = ST_IDLE;
        end else if (wr_s) begin
          tload    = 1'b1;
          state_nx = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if ((sel && rd_fall) || expired) begin
          latch    = 1'b1;
          state_nx = ST_IDLE;
        end
      end
      ST_RDCONV: begin
        if (expired) begin
          latch    = 1'b1;
          state_nx = ST_IDLE;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  logic done_r, done_nx;
  assign done_nx = latch ? 1'b1 : (start ? 1'b0 : done_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      start_conv <= 1'b0;
      latch_res  <= 1'b0;
      db_q       <= '0;
      ofl_n      <= 1'b1;
      int_n      <= 1'b1;
      rdy_oe     <= 1'b0;
      done_r     <= 1'b0;
      db_oe      <= 1'b0;
    end else begin
      state      <= state_nx;
      start_conv <= start;
      latch_res  <= latch;
      done_r     <= done_nx;
      db_oe      <= rd_act && (mode_s || done_nx);
      if (latch) begin
        db_q  <= conv_data;
        ofl_n <= ~conv_over;
      end
      if (latch)                           int_n <= 1'b0;
      else if (rd_rise || cs_rise || start) int_n <= 1'b1;
      if (latch)                              rdy_oe <= 1'b0;
      else if (cs_fall && !mode_s)            rdy_oe <= 1'b1;
      else if (cs_rise && state == ST_IDLE)   rdy_oe <= 1'b0;
    end
  end

  assign rdy_o = 1'b0;

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> !start_conv); // R11
  AST_INT_ON_LATCH: assert property (@(posedge clk) disable iff (rst)
    $fell(int_n) |-> latch_res); // R5
  AST_OFL_ON_LATCH: assert property (@(posedge clk) disable iff (rst)
    !$stable(ofl_n) |-> latch_res); // R10
  AST_DB_HIZ: assert property (@(posedge clk) disable iff (rst)
    db_oe |-> $past(!cs_s && !rd_s)); // R9
  AST_RDY_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_oe) |-> $past(!mode_s)); // R7
endmodule

// File: tb/sim_adc_bus_seq.sv
module sim_adc_bus_seq;
  localparam int DW = 8;
  localparam int TO = 100;
  localparam int CV = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mode = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic conv_over = 1'b0;
  logic start_conv, latch_res, db_oe, ofl_n, int_n, rdy_oe, rdy_o;
  logic [DW-1:0] db_q;

  int n_chk = 0, n_bad = 0, n_start = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_bus_seq #(.DATA_W(DW), .TIMEOUT_CYC(TO), .CONV_CYC(CV)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .mode(mode),
    .conv_data(conv_data), .conv_over(conv_over), .start_conv(start_conv),
    .latch_res(latch_res), .db_q(db_q), .db_oe(db_oe), .ofl_n(ofl_n),
    .int_n(int_n), .rdy_oe(rdy_oe), .rdy_o(rdy_o)
  );

  always @(posedge clk) if (!rst && start_conv) n_start++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset;
    check("R1 int_n", int_n, 1);
    check("R1 rdy_oe", rdy_oe, 0);
    check("R1 rdy_o", rdy_o, 0);
    check("R1 db_oe", db_oe, 0);
    check("R1 ofl_n", ofl_n, 1);
    check("R1 starts", n_start, 0);
  endtask

  task automatic t_cs_high;
    int s0 = n_start;
    mode = 1'b1; tick(5);
    wr_n = 1'b0; tick(5); wr_n = 1'b1; tick(3);
    rd_n = 1'b0; tick(5);
    check("R2 db_oe while cs high", db_oe, 0);
    rd_n = 1'b1; tick(TO + 10);
    check("R2 no start", n_start - s0, 0);
    check("R2 int_n", int_n, 1);
  endtask

  task automatic t_write_timeout;
    int s0 = n_start;
    conv_data = 8'hA5; conv_over = 1'b1;
    cs_n = 1'b0; tick(3);
    wr_n = 1'b0; tick(5);
    check("R3 one start", n_start - s0, 1);
    wr_n = 1'b1; tick(TO);
    check("R4 int_n before timeout", int_n, 1);
    check("R9 db_oe with rd high", db_oe, 0);
    tick(4);
    check("R4 int_n at timeout", int_n, 0);
    check("R10 ofl_n over range", ofl_n, 0);
    rd_n = 1'b0; tick(5);
    check("R9 db_oe write mode", db_oe, 1);
    check("R10 db_q", db_q, 8'hA5);
    rd_n = 1'b1; tick(5);
    check("R8 int_n cleared by rd", int_n, 1);
    check("R9 db_oe off", db_oe, 0);
    cs_n = 1'b1; tick(5);
  endtask

  task automatic t_early_read;
    conv_data = 8'h3C; conv_over = 1'b0;
    cs_n = 1'b0; tick(3);
    wr_n = 1'b0; tick(5); wr_n = 1'b1; tick(10);
    check("R5 int_n before read", int_n, 1);
    rd_n = 1'b0; tick(5);
    check("R5 int_n early", int_n, 0);
    check("R10 db_q early", db_q, 8'h3C);
    check("R10 ofl_n in range", ofl_n, 1);
    check("R9 db_oe", db_oe, 1);
    tick(TO);
    check("R5 int_n held", int_n, 0);
    rd_n = 1'b1; tick(5);
    check("R8 int_n rd rise", int_n, 1);
    cs_n = 1'b1; tick(5);
  endtask

  task automatic t_busy;
    int s0 = n_start;
    conv_data = 8'h5A;
    cs_n = 1'b0; tick(3);
    wr_n = 1'b0; tick(5); wr_n = 1'b1; tick(40);
    wr_n = 1'b0; tick(5); wr_n = 1'b1;
    tick(TO - 45 - 2);
    check("R11 int_n not yet", int_n, 1);
    tick(6);
    check("R11 latch at first timeout", int_n, 0);
    check("R11 single start", n_start - s0, 1);
    check("R10 db_q busy", db_q, 8'h5A);
    cs_n = 1'b1; tick(5);
    check("R8 int_n cs rise", int_n, 1);
  endtask

  task automatic t_read_mode;
    int s0;
    mode = 1'b0; conv_data = 8'h81; conv_over = 1'b0; tick(5);
    s0 = n_start;
    cs_n = 1'b0; tick(5);
    check("R7 rdy_oe after cs fall", rdy_oe, 1);
    check("R7 rdy_o", rdy_o, 0);
    rd_n = 1'b0; tick(5);
    check("R6 start", n_start - s0, 1);
    check("R6 db_oe held off", db_oe, 0);
    tick(CV - 4);
    check("R6 db_oe before done", db_oe, 0);
    check("R7 rdy_oe still", rdy_oe, 1);
    check("R6 int_n before done", int_n, 1);
    tick(4);
    check("R6 db_oe after done", db_oe, 1);
    check("R6 db_q", db_q, 8'h81);
    check("R6 int_n done", int_n, 0);
    check("R7 rdy released", rdy_oe, 0);
    cs_n = 1'b1; tick(5);
    check("R8 int_n cs rise", int_n, 1);
    check("R9 db_oe cs high", db_oe, 0);
    rd_n = 1'b1; tick(5);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_cs_high();
    t_write_timeout();
    t_early_read();
    t_busy();
    t_read_mode();
    finish_run();
  end
endmodule